// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block runs on the audio master clock and produces two derived clocks for a serial audio link: a bit clock and a left/right frame clock. The bit clock is the master clock divided by 2 or 4. The frame clock is the bit clock divided by 32, 64 or 128, with half of each frame given to each channel. Low on the frame clock marks the left channel.

A polarity setting picks which bit-clock edge the frame clock moves on. An override flag picks where the ratio and polarity settings come from. When the flag is set, they come from the block's own control fields. When it is clear, they come from a 4-bit external configuration input. A single enable gates both outputs.

New settings are taken only at a frame boundary, so a frame is never cut short. A frame-code value with no defined ratio parks the frame clock low until a valid code appears. The control is a three-state machine:

- `ST_OFF`: disabled. Both outputs are low and all counters are cleared.
- `ST_RUN`: the bit clock toggles and the frame clock counts bit-clock edges.
- `ST_HOLD`: an invalid frame code was seen. The bit clock keeps running and the frame clock is held low.

The transitions are:

- `ST_OFF` goes to `ST_RUN` on enable with a valid code, or to `ST_HOLD` on enable with the invalid code.
- `ST_RUN` goes to `ST_HOLD` when the code taken at a frame boundary is invalid.
- `ST_HOLD` goes to `ST_RUN` as soon as the selected code is valid.
- Any state goes to `ST_OFF` when the enable drops.

Top module: `i2s_clkgen`

## Requirements
- R1: The bit clock period is 2 master-clock cycles when the divide-by-4 select is 0, and 4 cycles when it is 1.
- R2: Frame codes 0, 1 and 2 give 32, 64 and 128 bit-clock periods per frame clock period. Each half of the frame lasts exactly half of that count, and the frame clock is low for the left half.
- R3: Frame code 3 is invalid. The frame clock stays low while the bit clock keeps toggling. The frame clock resumes once a valid code is selected.
- R4: With the enable low, both outputs are low from the first master-clock cycle after the enable is sampled low.
- R5: With the polarity select at 0, every frame-clock transition happens on a rising bit-clock edge. With it at 1, every transition happens on a falling bit-clock edge.
- R6: With the override flag at 1, the control fields set ratio and polarity. With it at 0, the external input sets them, encoded as bit 0 divide-by-4, bits 2:1 frame code and bit 3 polarity. The enable always comes from the control field.
- R7: A change of ratio or polarity takes effect at the next frame boundary, which is the high-to-low frame-clock transition. The half frame in progress completes with the old count.
- R8: After the enable rises, both outputs start low. The first frame-clock transition falls on the active bit-clock edge whose number equals the half-frame count.
- R9: During and right after reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Audio master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Output enable for both clocks |
| cfg_override | input | 1 | 1: use the cfg_* fields; 0: use ext_cfg |
| cfg_sclk_fall | input | 1 | 1: frame clock moves on falling bit-clock edges |
| cfg_frame_code | input | 2 | Frame ratio code (0/1/2 = 32/64/128; 3 invalid) |
| cfg_sclk_div4 | input | 1 | 0: bit clock = mclk/2; 1: mclk/4 |
| ext_cfg | input | 4 | External settings {polarity, frame code[1:0], div4} |
| sclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock, low = left channel |

## Verification
The frame boundary is the cycle where three things coincide: the bit-clock edge, the frame-clock fall, and the capture of new settings. The bench provokes this by changing the ratio in the middle of a right half. It then counts active bit-clock edges from the frame-clock rise to its fall (this must still be the old count) and from the fall to the next rise (this must be the new count). It also checks that every frame-clock transition lands in the same sampled cycle as a bit-clock edge of the selected direction.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;
    localparam int EXT_W     = 4;
    localparam int CODE_W    = 2;
    localparam int HALF_BASE = 16;
    localparam int LR_CODES  = 3;
    localparam int CNT_W     = $clog2(HALF_BASE << (LR_CODES - 1));
    localparam int PH_W      = 1;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } cg_state_t;

    typedef struct packed {
        logic              pol;
        logic [CODE_W-1:0] lr_code;
        logic              sdiv4;
    } clk_cfg_t;

    function automatic logic code_ok(input logic [CODE_W-1:0] code);
        return int'(code) < LR_CODES;
    endfunction

    function automatic logic [CNT_W-1:0] half_last(input logic [CODE_W-1:0] code);
        int v;
        v = (HALF_BASE << code) - 1;
        return CNT_W'(v);
    endfunction
endpackage

// File: rtl/i2s_cfg_sel.sv
module i2s_cfg_sel
    import i2s_clkgen_pkg::*;
(
    input  logic              override_i,
    input  logic              pol_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              div4_i,
    input  logic [EXT_W-1:0]  ext_i,
    output clk_cfg_t          cfg_o
);
    clk_cfg_t reg_cfg;
    clk_cfg_t ext_cfg;

    always_comb begin
        reg_cfg.pol     = pol_i;
        reg_cfg.lr_code = code_i;
        reg_cfg.sdiv4   = div4_i;
        ext_cfg         = clk_cfg_t'(ext_i);
        cfg_o           = override_i ? reg_cfg : ext_cfg;
    end
endmodule

// File: rtl/i2s_sclk_gen.sv
module i2s_sclk_gen
    import i2s_clkgen_pkg::*;
(
    input  logic mclk,
    input  logic rst_n,
    input  logic run_i,
    input  logic div4_i,
    output logic tog_o,
    output logic sclk_o
);
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] lim;

    assign lim   = div4_i ? PH_W'(1) : PH_W'(0);
    assign tog_o = run_i && (ph_q >= lim);

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            sclk_o <= 1'b0;
        end else if (!run_i) begin
            ph_q   <= '0;
            sclk_o <= 1'b0;
        end else if (tog_o) begin
            ph_q   <= '0;
            sclk_o <= ~sclk_o;
        end else begin
            ph_q   <= ph_q + PH_W'(1);
        end
    end
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
    import i2s_clkgen_pkg::*;
(
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_override,
    input  logic              cfg_sclk_fall,
    input  logic [CODE_W-1:0] cfg_frame_code,
    input  logic              cfg_sclk_div4,
    input  logic [EXT_W-1:0]  ext_cfg,
    output logic              sclk_o,
    output logic              lrclk_o
);
    cg_state_t        state_q, state_d;
    clk_cfg_t         sel_cfg;
    clk_cfg_t         act_cfg;
    logic [CNT_W-1:0] bcnt_q;
    logic             lr_q;
    logic             run;
    logic             tog;
    logic             sclk;
    logic             act_edge;
    logic             half_end;
    logic             frame_end;

    i2s_cfg_sel u_sel (
        .override_i (cfg_override),
        .pol_i      (cfg_sclk_fall),
        .code_i     (cfg_frame_code),
        .div4_i     (cfg_sclk_div4),
        .ext_i      (ext_cfg),
        .cfg_o      (sel_cfg)
    );

    assign run = cfg_enable && (state_q != ST_OFF);

    i2s_sclk_gen u_sclk (
        .mclk   (mclk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div4_i (act_cfg.sdiv4),
        .tog_o  (tog),
        .sclk_o (sclk)
    );

    assign act_edge  = tog && (sclk == act_cfg.pol);
    assign half_end  = act_edge && (bcnt_q == half_last(act_cfg.lr_code));
    assign frame_end = half_end && lr_q;

    // state register
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cfg_enable)
                    state_d = code_ok(sel_cfg.lr_code) ? ST_RUN : ST_HOLD;
            end
            ST_RUN: begin
                if (!cfg_enable)
                    state_d = ST_OFF;
                else if (frame_end && !code_ok(sel_cfg.lr_code))
                    state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!cfg_enable)
                    state_d = ST_OFF;
                else if (code_ok(sel_cfg.lr_code))
                    state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs and counters
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            lr_q    <= 1'b0;
            bcnt_q  <= '0;
            act_cfg <= '0;
        end else if (!cfg_enable) begin
            lr_q    <= 1'b0;
            bcnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_OFF, ST_HOLD: begin
                    lr_q    <= 1'b0;
                    bcnt_q  <= '0;
                    act_cfg <= sel_cfg;
                end
                ST_RUN: begin
                    if (half_end) begin
                        lr_q   <= ~lr_q;
                        bcnt_q <= '0;
                        if (lr_q) act_cfg <= sel_cfg;
                    end else if (act_edge) begin
                        bcnt_q <= bcnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    lr_q   <= 1'b0;
                    bcnt_q <= '0;
                end
            endcase
        end
    end

    assign sclk_o  = sclk;
    assign lrclk_o = lr_q;
endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk
    import i2s_clkgen_pkg::*;
(
    input logic              mclk,
    input logic              rst_n,
    input logic              en,
    input logic              sclk_o,
    input logic              lrclk_o,
    input cg_state_t         state,
    input logic [CODE_W-1:0] act_code
);
    p_off_low_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        !en |=> (!sclk_o && !lrclk_o));

    p_lr_on_sclk_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        ($past(en) && (lrclk_o != $past(lrclk_o))) |-> (sclk_o != $past(sclk_o)));

    p_hold_lr_low_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !lrclk_o);

    p_run_code_ok_r2: assert property (@(posedge mclk) disable iff (!rst_n)
        (state == ST_RUN) |-> (act_code != 2'd3));
endmodule

bind i2s_clkgen i2s_clkgen_chk u_chk (
    .mclk     (mclk),
    .rst_n    (rst_n),
    .en       (cfg_enable),
    .sclk_o   (sclk_o),
    .lrclk_o  (lrclk_o),
    .state    (state_q),
    .act_code (act_cfg.lr_code)
);

// File: tb/sim_i2s_clkgen.sv
module sim_i2s_clkgen;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       ovr;
        logic       pol;
        logic [1:0] code;
        logic       sdiv;
        int         exp_half;
        int         exp_per;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b0, 2'd0, 1'b0, 16, 2},
        '{1'b1, 1'b1, 2'd1, 1'b0, 32, 2},
        '{1'b1, 1'b0, 2'd2, 1'b1, 64, 4},
        '{1'b1, 1'b1, 2'd0, 1'b1, 16, 4},
        '{1'b0, 1'b0, 2'd1, 1'b1, 32, 4},
        '{1'b0, 1'b1, 2'd2, 1'b0, 64, 2},
        '{1'b0, 1'b1, 2'd0, 1'b0, 16, 2},
        '{1'b1, 1'b0, 2'd1, 1'b0, 32, 2}
    };

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, ovr = 1'b1, pol = 1'b0, div4 = 1'b0;
    logic [1:0] code = 2'd0;
    logic [3:0] ext = 4'd0;
    logic       sclk_o, lrclk_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) mclk = ~mclk;

    i2s_clkgen u0 (
        .mclk(mclk), .rst_n(rst_n), .cfg_enable(en), .cfg_override(ovr),
        .cfg_sclk_fall(pol), .cfg_frame_code(code), .cfg_sclk_div4(div4),
        .ext_cfg(ext), .sclk_o(sclk_o), .lrclk_o(lrclk_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic watch(input int ncyc, input bit p, output int hmin, output int hmax,
                         output int ntog, output int mis, output int pmin, output int pmax);
        bit ps, pl, started;
        int edges, last_rise;
        hmin = 9999; hmax = 0; ntog = 0; mis = 0; pmin = 9999; pmax = 0;
        started = 0; edges = 0; last_rise = -1;
        ps = sclk_o; pl = lrclk_o;
        for (int c = 1; c <= ncyc; c++) begin
            bit act;
            @(negedge mclk);
            act = (sclk_o != ps) && (sclk_o == !p);
            if (sclk_o && !ps) begin
                if (last_rise >= 0) begin
                    if (c - last_rise < pmin) pmin = c - last_rise;
                    if (c - last_rise > pmax) pmax = c - last_rise;
                end
                last_rise = c;
            end
            if (act) edges++;
            if (lrclk_o != pl) begin
                ntog++;
                if (!act) mis++;
                if (started) begin
                    if (edges < hmin) hmin = edges;
                    if (edges > hmax) hmax = edges;
                end
                started = 1;
                edges = 0;
            end
            ps = sclk_o; pl = lrclk_o;
        end
    endtask

    // counts active edges until the frame clock changes; returns edge count
    task automatic edges_to_toggle(input bit p, output int n);
        bit ps, pl;
        n = 0; ps = sclk_o; pl = lrclk_o;
        for (int c = 0; c < 2000; c++) begin
            @(negedge mclk);
            if ((sclk_o != ps) && (sclk_o == !p)) n++;
            if (lrclk_o != pl) break;
            ps = sclk_o; pl = lrclk_o;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int hmin, hmax, ntog, mis, pmin, pmax, n;
        // R9 reset state
        repeat (3) @(negedge mclk);
        chk("R9 sclk in reset", int'(sclk_o), 0);
        chk("R9 lrclk in reset", int'(lrclk_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge mclk);
        chk("R9 outputs after reset", int'(sclk_o | lrclk_o), 0);

        // vector table walk: R1 R2 R5 R6
        foreach (VEC[i]) begin
            vec_t v;
            v = VEC[i];
            en = 1'b0;
            @(negedge mclk);
            ovr = v.ovr;
            if (v.ovr) begin
                pol = v.pol; code = v.code; div4 = v.sdiv;
                ext = {~v.pol, (v.code == 2'd0) ? 2'd2 : 2'd0, ~v.sdiv};
            end else begin
                ext = {v.pol, v.code, v.sdiv};
                pol = ~v.pol; code = (v.code == 2'd0) ? 2'd2 : 2'd0; div4 = ~v.sdiv;
            end
            en = 1'b1;
            watch(6 * v.exp_half * v.exp_per + 40, v.pol, hmin, hmax, ntog, mis, pmin, pmax);
            chk(v.ovr ? "R1 sclk period min" : "R6 R1 sclk period min", pmin, v.exp_per);
            chk(v.ovr ? "R1 sclk period max" : "R6 R1 sclk period max", pmax, v.exp_per);
            chk(v.ovr ? "R2 half min" : "R6 R2 half min", hmin, v.exp_half);
            chk(v.ovr ? "R2 half max" : "R6 R2 half max", hmax, v.exp_half);
            chk("R5 lrclk on selected sclk edge", mis, 0);
            chk("R2 frame toggles seen", int'(ntog >= 4), 1);
        end

        // R4 disable
        @(negedge mclk);
        en = 1'b0;
        @(negedge mclk);
        chk("R4 outputs low after disable", int'(sclk_o | lrclk_o), 0);
        watch(60, 1'b0, hmin, hmax, ntog, mis, pmin, pmax);
        chk("R4 no activity while disabled", int'(ntog != 0 || pmax != 0 || sclk_o), 0);

        // R8 aligned restart
        ovr = 1'b1; pol = 1'b0; code = 2'd0; div4 = 1'b0;
        en = 1'b1;
        edges_to_toggle(1'b0, n);
        chk("R8 first toggle edge number", n, 16);
        chk("R8 first toggle goes high", int'(lrclk_o), 1);

        // R7 ratio change inside the right half
        repeat (5) begin
            bit ps;
            ps = sclk_o;
            do begin ps = sclk_o; @(negedge mclk); end while (!(sclk_o && !ps));
        end
        code = 2'd1;
        edges_to_toggle(1'b0, n);
        chk("R7 old half completes", n + 5, 16);
        chk("R7 boundary is fall", int'(lrclk_o), 0);
        edges_to_toggle(1'b0, n);
        chk("R7 new ratio after boundary", n, 32);

        // R3 invalid code
        en = 1'b0;
        @(negedge mclk);
        code = 2'd3; en = 1'b1;
        watch(600, 1'b0, hmin, hmax, ntog, mis, pmin, pmax);
        chk("R3 lrclk held", ntog + int'(lrclk_o), 0);
        chk("R3 sclk keeps running", pmax, 2);
        code = 2'd0;
        watch(200, 1'b0, hmin, hmax, ntog, mis, pmin, pmax);
        chk("R3 resumes with valid code", hmax, 16);
        chk("R3 resumed toggles", int'(ntog >= 4), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule